// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

This block is a memory-mapped real-time clock. It runs on the system clock and receives a one-cycle timebase strobe (nominally 32.768 kHz) on `tb_en_i`. A programmable divide count turns those strobes into a tick. With a divide count of 32767 the tick comes once per second. A trim field shortens one interval in every `TRIM_PERIOD` ticks by a programmed number of strobes, which corrects slow crystal drift. Each tick advances a 32-bit seconds counter. An alarm register is compared against the new counter value as it advances.

A combined status/control word holds two interrupt enables and two sticky event flags. One flag is set by the tick and one by the alarm match. Software clears a flag by writing a one to its bit. Two level interrupt outputs carry each flag gated by its enable. Software reaches everything through a simple single-cycle 32-bit read/write port. Reads are combinational.

Top module: `rtc_top`

## Requirements
- R1: After reset every register reads zero, and both interrupt outputs are low.
- R2: With divide count D non-zero, a tick occurs after every D+1 timebase strobes. Each tick adds one to the seconds counter. No strobes means no change.
- R3: While the divide count is zero, no tick occurs and the seconds counter holds.
- R4: In every `TRIM_PERIOD`-th tick interval, the interval is shortened by the trim value, to no fewer than one strobe. Other intervals are not shortened.
- R5: The offsets are: 0x00 alarm, 0x04 seconds, 0x08 divider (divide count in bits 15:0, trim in bits 25:16, other bits read zero), and 0x10 status. A write to 0x04 loads the counter, and a read returns the current count.
- R6: The status word has bit 3 = tick interrupt enable, bit 2 = alarm interrupt enable, bit 1 = tick flag and bit 0 = alarm flag. The enables are written directly and read back.
- R7: The flags are sticky. Writing one to bit 1 or bit 0 clears that flag. Writing zero to a flag bit leaves it unchanged.
- R8: Every tick sets the tick flag.
- R9: The alarm flag is set when a tick advances the counter to the alarm value.
- R10: `irq_tick_o` equals tick flag AND tick enable. `irq_alarm_o` equals alarm flag AND alarm enable. Both are levels.
- R11: When a flag is set and cleared by a write in the same cycle, the flag ends at one.
- R12: Reads of any other offset return zero. Writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tb_en_i | input | 1 | Timebase strobe, one cycle per timebase period |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| irq_tick_o | output | 1 | Tick interrupt level |
| irq_alarm_o | output | 1 | Alarm interrupt level |

## Verification
The bench builds the block with `TRIM_PERIOD` = 4 and keeps `DIV_W` = 16 and `TRIM_W` = 10. It programs a divide count of 3, so a tick takes four strobes and the trimmed interval comes round after four ticks; this keeps the trim behaviour within a few dozen cycles. The strobe is driven as exact bursts, so the bench knows how many ticks each burst produces. It also knows the cycle in which a tick flag is set, which lets it place a clearing write into that same cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned TRIM_LSB = 16;

  localparam logic [7:0] OFF_ALARM = 8'h00;
  localparam logic [7:0] OFF_SEC   = 8'h04;
  localparam logic [7:0] OFF_DIV   = 8'h08;
  localparam logic [7:0] OFF_STAT  = 8'h10;

  localparam int unsigned ST_TICK_EN  = 3;
  localparam int unsigned ST_ALARM_EN = 2;
  localparam int unsigned ST_TICK_FL  = 1;
  localparam int unsigned ST_ALARM_FL = 0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ALARM,
    SEL_SEC,
    SEL_DIV,
    SEL_STAT
  } reg_sel_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned TRIM_W      = 10,
  parameter int unsigned TRIM_PERIOD = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tb_en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [TRIM_W-1:0] trim_i,
  output logic              tick_o
);
  localparam int unsigned IDX_W = (TRIM_PERIOD > 1) ? $clog2(TRIM_PERIOD) : 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] limit;
  logic [DIV_W-1:0] trim_ext;
  logic             trim_slot;
  logic             running;
  logic             wrap;
  logic             tick_q;

  generate
    if (TRIM_PERIOD > 1) begin : g_idx
      logic [IDX_W-1:0] idx_q;
      assign trim_slot = (idx_q == IDX_W'(TRIM_PERIOD - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    idx_q <= '0;
        else if (wrap)  idx_q <= trim_slot ? '0 : idx_q + IDX_W'(1);
      end
    end else begin : g_no_idx
      assign trim_slot = 1'b1;
    end
  endgenerate

  assign trim_ext = DIV_W'(trim_i);

  always_comb begin
    limit = div_i;
    if (trim_slot) limit = (trim_ext < div_i) ? div_i - trim_ext : '0;
  end

  assign running = tb_en_i && (div_i != '0);
  assign wrap    = running && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap;
      if (running) cnt_q <= wrap ? '0 : cnt_q + DIV_W'(1);
    end
  end

  assign tick_o = tick_q;

  assert_no_tick_div0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i == '0) |=> !tick_o);
  assert_tick_needs_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tb_en_i |=> !tick_o);
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
  import rtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_sec_i,
  input  logic             wr_alarm_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] sec_o,
  output logic [REG_W-1:0] alarm_o,
  output logic             match_o
);
  logic [REG_W-1:0] sec_q;
  logic [REG_W-1:0] alarm_q;
  logic [REG_W-1:0] sec_inc;

  assign sec_inc = sec_q + REG_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q   <= '0;
      alarm_q <= '0;
    end else begin
      if (wr_sec_i)    sec_q <= wdata_i;
      else if (tick_i) sec_q <= sec_inc;
      if (wr_alarm_i)  alarm_q <= wdata_i;
    end
  end

  // match only on an advancing tick; a software load does not raise it
  assign match_o = tick_i && !wr_sec_i && (sec_inc == alarm_q);
  assign sec_o   = sec_q;
  assign alarm_o = alarm_q;

  assert_sec_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_sec_i) |=> (sec_o == $past(sec_o) + REG_W'(1)));
  assert_sec_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_sec_i) |=> $stable(sec_o));
  assert_sec_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sec_i |=> (sec_o == $past(wdata_i)));
endmodule

// File: rtl/rtc_status.sv
module rtc_status
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [3:0] wdata_i,
  input  logic       set_tick_i,
  input  logic       set_alarm_i,
  output logic [3:0] stat_o,
  output logic       irq_tick_o,
  output logic       irq_alarm_o
);
  logic en_tick_q, en_alarm_q, fl_tick_q, fl_alarm_q;
  logic clr_tick, clr_alarm;

  assign clr_tick  = wr_i && wdata_i[ST_TICK_FL];
  assign clr_alarm = wr_i && wdata_i[ST_ALARM_FL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_tick_q  <= 1'b0;
      en_alarm_q <= 1'b0;
      fl_tick_q  <= 1'b0;
      fl_alarm_q <= 1'b0;
    end else begin
      if (wr_i) begin
        en_tick_q  <= wdata_i[ST_TICK_EN];
        en_alarm_q <= wdata_i[ST_ALARM_EN];
      end
      // set has priority over a same-cycle clear
      fl_tick_q  <= set_tick_i  || (fl_tick_q  && !clr_tick);
      fl_alarm_q <= set_alarm_i || (fl_alarm_q && !clr_alarm);
    end
  end

  always_comb begin
    stat_o              = '0;
    stat_o[ST_TICK_EN]  = en_tick_q;
    stat_o[ST_ALARM_EN] = en_alarm_q;
    stat_o[ST_TICK_FL]  = fl_tick_q;
    stat_o[ST_ALARM_FL] = fl_alarm_q;
  end

  assign irq_tick_o  = fl_tick_q  && en_tick_q;
  assign irq_alarm_o = fl_alarm_q && en_alarm_q;

  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_tick_q && !clr_tick) |=> fl_tick_q);
  assert_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_alarm && !set_alarm_i) |=> !fl_alarm_q);
  assert_tick_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_tick_i |=> fl_tick_q);
  assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_alarm_i && clr_alarm) |=> fl_alarm_q);
endmodule

// File: rtl/rtc_top.sv
module rtc_top
  import rtc_pkg::*;
#(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned TRIM_W      = 10,
  parameter int unsigned TRIM_PERIOD = 1024,
  parameter int unsigned ADDR_W      = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tb_en_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_tick_o,
  output logic              irq_alarm_o
);
  reg_sel_e          sel;
  logic              wr;
  logic [DIV_W-1:0]  div_q;
  logic [TRIM_W-1:0] trim_q;
  logic              tick;
  logic              match;
  logic [REG_W-1:0]  sec;
  logic [REG_W-1:0]  alarm;
  logic [3:0]        stat;
  logic [REG_W-1:0]  rd_val;

  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFF_ALARM): sel = SEL_ALARM;
      ADDR_W'(OFF_SEC):   sel = SEL_SEC;
      ADDR_W'(OFF_DIV):   sel = SEL_DIV;
      ADDR_W'(OFF_STAT):  sel = SEL_STAT;
      default:            sel = SEL_NONE;
    endcase
  end

  assign wr = req_i && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      trim_q <= '0;
    end else if (wr && sel == SEL_DIV) begin
      div_q  <= wdata_i[DIV_W-1:0];
      trim_q <= wdata_i[TRIM_LSB +: TRIM_W];
    end
  end

  rtc_prescaler #(
    .DIV_W(DIV_W), .TRIM_W(TRIM_W), .TRIM_PERIOD(TRIM_PERIOD)
  ) u_prescaler (
    .clk_i(clk_i), .rst_ni(rst_ni), .tb_en_i(tb_en_i),
    .div_i(div_q), .trim_i(trim_q), .tick_o(tick)
  );

  rtc_sec_counter u_sec (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .wr_sec_i(wr && sel == SEL_SEC), .wr_alarm_i(wr && sel == SEL_ALARM),
    .wdata_i(wdata_i), .sec_o(sec), .alarm_o(alarm), .match_o(match)
  );

  rtc_status u_status (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr && sel == SEL_STAT), .wdata_i(wdata_i[3:0]),
    .set_tick_i(tick), .set_alarm_i(match),
    .stat_o(stat), .irq_tick_o(irq_tick_o), .irq_alarm_o(irq_alarm_o)
  );

  always_comb begin
    rd_val = '0;
    unique case (sel)
      SEL_ALARM: rd_val = alarm;
      SEL_SEC:   rd_val = sec;
      SEL_DIV: begin
        rd_val[DIV_W-1:0]           = div_q;
        rd_val[TRIM_LSB +: TRIM_W]  = trim_q;
      end
      SEL_STAT:  rd_val[3:0] = stat;
      default:   rd_val = '0;
    endcase
  end

  assign rdata_o = (req_i && !we_i) ? rd_val : '0;

  assert_alarm_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && stat[ST_ALARM_EN] && !(wr && sel == SEL_STAT)) |=> irq_alarm_o);
  assert_div_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && sel == SEL_DIV) |=> ($stable(div_q) && $stable(trim_q)));
endmodule

// File: tb/rtc_top_bench.sv
`timescale 1ns/1ps
module rtc_top_bench;
  localparam int unsigned TP = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tb_en = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_tick, irq_alarm;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [4:0]  a;
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];
  event mon_ev;

  always #2.5 clk = ~clk;

  rtc_top #(.DIV_W(16), .TRIM_W(10), .TRIM_PERIOD(TP), .ADDR_W(5)) u_rtc_top (
    .clk_i(clk), .rst_ni(rst_ni), .tb_en_i(tb_en), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_tick_o(irq_tick), .irq_alarm_o(irq_alarm)
  );

  // monitor: pops expected reads and compares
  initial begin
    forever begin
      @(mon_ev);
      while (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        n_tests++;
        if (rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s: read 0x%02h got 0x%08h expected 0x%08h", it.tag, it.a, rdata, it.exp);
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; tb_en = 1'b0; req = 1'b0; we = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #0.5;
    it.a = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    -> mon_ev;
    #0.5;
    req = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tb_en = 1'b1;
    end
    @(negedge clk);
    tb_en = 1'b0;
  endtask

  task automatic chk_bit(input logic act, input logic e, input string tag);
    n_tests++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    rd(5'h00, 32'h0, "R1 alarm");
    rd(5'h04, 32'h0, "R1 seconds");
    rd(5'h08, 32'h0, "R1 divider");
    rd(5'h10, 32'h0, "R1 status");
    @(negedge clk);
    chk_bit(irq_tick, 1'b0, "R1 irq_tick");
    chk_bit(irq_alarm, 1'b0, "R1 irq_alarm");

    // R3 zero divide count holds
    pulse(20);
    rd(5'h04, 32'h0, "R3 seconds with divide 0");
    rd(5'h10, 32'h0, "R3 no tick flag");

    // R2 / R5 / R8 counting
    wr(5'h08, 32'd3);
    wr(5'h04, 32'd100);
    rd(5'h04, 32'd100, "R5 seconds load");
    pulse(12);
    rd(5'h04, 32'd103, "R2 three ticks");
    rd(5'h10, 32'h2, "R8 tick flag");
    @(negedge clk);
    chk_bit(irq_tick, 1'b0, "R10 tick irq masked");
    repeat (10) @(negedge clk);
    rd(5'h04, 32'd103, "R2 hold without strobe");

    // R6 / R7 / R10 status
    wr(5'h10, 32'h8);
    rd(5'h10, 32'hA, "R6 enable written");
    @(negedge clk);
    chk_bit(irq_tick, 1'b1, "R10 tick irq on");
    wr(5'h10, 32'h8);
    rd(5'h10, 32'hA, "R7 zero write keeps flag");
    wr(5'h10, 32'hA);
    rd(5'h10, 32'h8, "R7 one write clears flag");
    @(negedge clk);
    chk_bit(irq_tick, 1'b0, "R10 tick irq off");
    wr(5'h10, 32'h0);
    rd(5'h10, 32'h0, "R6 enable cleared");

    // R4 trim: intervals 4,4,4,2 with divide 3, trim 2, period 4
    do_reset();
    wr(5'h08, (32'd2 << 16) | 32'd3);
    rd(5'h08, 32'h0002_0003, "R5 divider readback");
    pulse(12);
    rd(5'h04, 32'd3, "R4 untrimmed intervals");
    pulse(2);
    rd(5'h04, 32'd4, "R4 trimmed interval");
    pulse(14);
    rd(5'h04, 32'd8, "R4 trim repeats");

    // R9 / R10 alarm
    do_reset();
    wr(5'h08, 32'd3);
    wr(5'h00, 32'd5);
    wr(5'h04, 32'd3);
    wr(5'h10, 32'h4);
    pulse(4);
    rd(5'h10, 32'h6, "R9 no alarm before match");
    @(negedge clk);
    chk_bit(irq_alarm, 1'b0, "R10 alarm irq low");
    pulse(4);
    rd(5'h04, 32'd5, "R9 seconds at alarm");
    rd(5'h10, 32'h7, "R9 alarm flag set");
    @(negedge clk);
    chk_bit(irq_alarm, 1'b1, "R10 alarm irq high");
    pulse(4);
    rd(5'h10, 32'h7, "R7 alarm flag sticky");
    wr(5'h10, 32'h5);
    rd(5'h10, 32'h6, "R7 alarm flag cleared");
    @(negedge clk);
    chk_bit(irq_alarm, 1'b0, "R10 alarm irq cleared");

    // R11 set wins over same-cycle clear
    do_reset();
    wr(5'h08, 32'd3);
    wr(5'h10, 32'h8);
    pulse(3);
    @(negedge clk);
    tb_en = 1'b1;
    @(negedge clk);
    tb_en = 1'b0;
    req = 1'b1; we = 1'b1; addr = 5'h10; wdata = 32'hB;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    rd(5'h10, 32'hA, "R11 set wins");
    wr(5'h10, 32'hB);
    rd(5'h10, 32'h8, "R11 later clear works");

    // R12 unmapped offsets
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h02, 32'hFFFF_FFFF);
    rd(5'h0C, 32'h0, "R12 read 0x0C");
    rd(5'h14, 32'h0, "R12 read 0x14");
    rd(5'h00, 32'h0, "R12 alarm untouched");
    rd(5'h04, 32'd1, "R12 seconds untouched");
    rd(5'h08, 32'd3, "R12 divider untouched");
    rd(5'h10, 32'h8, "R12 status untouched");

    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, 32'h03FF_FFFF, "R5 divider field mask");

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule